// File: doc/BRIEF.md
# Cascaded Prescaler Reload Timer

The block is a two-stage periodic tick generator. A free-running four-bit divider turns the system clock into a count enable that fires once every sixteen clocks. That enable drives an 8-bit reloadable down-counter, the prescaler. The prescaler's underflow events drive a second 8-bit reloadable down-counter, the timer. Each stage keeps a reload latch. When a stage's counter already holds zero, the next count pulse reloads it from its latch. For reload values n and m, the timer therefore underflows once every 16·(n+1)·(m+1) clocks.

Software reaches the block through a small register bus: a two-bit address, write data, a write strobe and combinational read data. Writing a stage's register sets both its latch and its live counter. Reading a stage's register returns the live count. A control register carries a halt bit that freezes both stages. Every timer underflow sets an interrupt request flag. The flag stays set until the dedicated clear input is pulsed.

Top module: `tick_chain_timer`

## Requirements
- R1: After reset, both counters and both latches hold 0xFF, the halt bit is 0 and irqReq is 0.
- R2: The divider runs freely from reset and yields one count enable every 16 clocks: on the clock edge that ends the 16th, 32nd, 48th, ... cycle after reset release.
- R3: On each count enable the prescaler decrements by 1. When it already holds 0, it reloads from its latch instead and produces one underflow event. Its division ratio is therefore 1/(n+1) for reload value n.
- R4: The timer changes only on a prescaler underflow event. On that event it decrements by 1, or reloads from its latch if it holds 0. Its division ratio is 1/(m+1).
- R5: A write to address 0 loads the write data into both the prescaler latch and the prescaler counter. Reading address 0 returns the live prescaler count.
- R6: A write to address 1 loads the write data into both the timer latch and the timer counter. Reading address 1 returns the live timer count.
- R7: A timer underflow sets irqReq on the following edge. irqClear clears it. If both happen in the same cycle, the set wins.
- R8: Address 2 bit 0 is the halt bit. While it is 1, neither stage counts, but the divider keeps its phase. Reading address 2 returns {7'b0, halt}.
- R9: A write to a stage in the same cycle as that stage's count pulse takes priority. The decrement is dropped, and no underflow event leaves that stage.
- R10: Address 3 reads as 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 8 | Read data for busAddr, combinational |
| irqClear | input | 1 | Clears the interrupt request flag |
| irqReq | output | 1 | Timer underflow interrupt request flag |

## Verification
A wrong divider phase or a wrong counter value shows up at once in the read data for the affected stage. The bench reads the live count every cycle, so a corrupted prescaler is visible within 16 clocks, at its next enable. A timer fault shows after the next prescaler underflow. A lost or extra underflow shows as an irqReq edge that comes early, comes late or never comes. This reveals itself within one full timer period, which is 96 clocks at the short reload values the bench uses. The bench places writes on the exact enable cycle and pulses the clear input against a pending set, so the priority rules are visible at the ports in the cycle after the collision.

// File: rtl/tick_chain_pkg.sv
package tick_chain_pkg;
  localparam int STAGES = 2;

  typedef struct packed {
    logic [STAGES-1:0] stageWr;
    logic              cntTick;
    logic              irqClr;
  } ctlStrobes_t;
endpackage

// File: rtl/tick_chain_ctrl.sv
module tick_chain_ctrl
  import tick_chain_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              haltWrBit,
  input  logic              irqClear,
  output ctlStrobes_t       strobes,
  output logic              halted
);
  localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(STAGES);

  logic [DIV_W-1:0] divCnt;
  logic             haltBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              haltBit <= 1'b0;
    else if (busWe && busAddr == CTL_ADDR)  haltBit <= haltWrBit;
  end

  always_comb begin
    strobes = '0;
    for (int s = 0; s < STAGES; s++)
      strobes.stageWr[s] = busWe && (busAddr == ADDR_W'(s));
    strobes.cntTick = (divCnt == DIV_LAST) && !haltBit;
    strobes.irqClr  = irqClear;
  end

  assign halted = haltBit;

  // R2: enables are isolated single-cycle pulses
  a_r2_tick_single: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntTick |=> !strobes.cntTick);

  // R8: a halted block issues no count enable
  a_r8_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == CTL_ADDR && haltWrBit) |=> !strobes.cntTick);

  // R5/R6: write strobes are one-hot at most
  a_r5_wr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.stageWr));
endmodule

// File: rtl/tick_chain_datapath.sv
module tick_chain_datapath
  import tick_chain_pkg::*;
#(
  parameter int            CNT_W     = 8,
  parameter logic [CNT_W-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] preCount,
  output logic [CNT_W-1:0] tmrCount,
  output logic             irqFlag
);
  logic [CNT_W-1:0] cnt [STAGES];
  logic [CNT_W-1:0] lat [STAGES];
  logic [STAGES:0]  stageEn;
  logic [STAGES-1:0] stageUf;

  assign stageEn[0] = strobes.cntTick;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    assign stageUf[s]   = stageEn[s] && (cnt[s] == '0) && !strobes.stageWr[s];
    assign stageEn[s+1] = stageUf[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[s] <= RESET_VAL;
        lat[s] <= RESET_VAL;
      end else if (strobes.stageWr[s]) begin
        cnt[s] <= busWdata;
        lat[s] <= busWdata;
      end else if (stageEn[s]) begin
        cnt[s] <= (cnt[s] == '0) ? lat[s] : cnt[s] - 1'b1;
      end
    end

    // R3/R4: reaching zero then pulsing reloads from the latch
    a_r3_reload: assert property (@(posedge clk) disable iff (!rstN)
      (stageEn[s] && cnt[s] == '0 && !strobes.stageWr[s]) |=> cnt[s] == $past(lat[s]));

    // R4: without a pulse or write the counter holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!stageEn[s] && !strobes.stageWr[s]) |=> $stable(cnt[s]));

    // R9: a write wins over a coincident count pulse
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobes.stageWr[s] |=> (cnt[s] == $past(busWdata) && lat[s] == $past(busWdata)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     irqFlag <= 1'b0;
    else if (stageUf[STAGES-1])    irqFlag <= 1'b1;
    else if (strobes.irqClr)       irqFlag <= 1'b0;
  end

  assign preCount = cnt[0];
  assign tmrCount = cnt[STAGES-1];

  // R7: timer underflow always raises the request
  a_r7_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    stageUf[STAGES-1] |=> irqFlag);

  // R7: request only drops on a clear
  a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> $past(strobes.irqClr));
endmodule

// File: rtl/tick_chain_timer.sv
module tick_chain_timer
  import tick_chain_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  input  logic              busWe,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              irqClear,
  output logic              irqReq
);
  ctlStrobes_t      strobes;
  logic             halted;
  logic [CNT_W-1:0] preCount;
  logic [CNT_W-1:0] tmrCount;

  tick_chain_ctrl #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .haltWrBit(busWdata[0]), .irqClear(irqClear),
    .strobes(strobes), .halted(halted)
  );

  tick_chain_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWdata(busWdata),
    .preCount(preCount), .tmrCount(tmrCount), .irqFlag(irqReq)
  );

  always_comb begin
    case (busAddr)
      ADDR_W'(0): busRdata = preCount;
      ADDR_W'(1): busRdata = tmrCount;
      ADDR_W'(2): busRdata = {{(CNT_W-1){1'b0}}, halted};
      default:    busRdata = '0;
    endcase
  end
endmodule

// File: tb/tick_chain_timer_bench.sv
module tick_chain_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWe = 1'b0;
  logic [7:0] busRdata;
  logic       irqClear = 1'b0;
  logic       irqReq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int mDiv, mPre, mPreLat, mTm, mTmLat, mHalt, mIrq;
  int cycle = 0;

  tick_chain_timer u_tick_chain_timer (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .irqClear(irqClear), .irqReq(irqReq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cycle);
    end
  endtask

  function automatic int modelRead(input int a);
    case (a)
      0: return mPre;
      1: return mTm;
      2: return mHalt;
      default: return 0;
    endcase
  endfunction

  function automatic string readTag(input int a);
    case (a)
      0: return "R5 prescaler count (R2 R3 R9)";
      1: return "R6 timer count (R4 R9)";
      2: return "R8 halt bit";
      default: return "R10 unused address";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mDiv = 0; mPre = 255; mPreLat = 255; mTm = 255; mTmLat = 255; mHalt = 0; mIrq = 0;
    end else begin
      bit tick, preWr, tmWr, preUf, tmUf;
      tick  = (mDiv == 15) && (mHalt == 0);
      preWr = busWe && busAddr == 0;
      tmWr  = busWe && busAddr == 1;
      preUf = tick && mPre == 0 && !preWr;
      tmUf  = preUf && mTm == 0 && !tmWr;
      if (preWr) begin mPre = busWdata; mPreLat = busWdata; end
      else if (tick) mPre = (mPre == 0) ? mPreLat : mPre - 1;
      if (tmWr) begin mTm = busWdata; mTmLat = busWdata; end
      else if (preUf) mTm = (mTm == 0) ? mTmLat : mTm - 1;
      if (busWe && busAddr == 2) mHalt = busWdata[0];
      if (tmUf) mIrq = 1;
      else if (irqClear) mIrq = 0;
      mDiv = (mDiv + 1) % 16;
      cycle++;
      #5;
      check(readTag(busAddr), busRdata, modelRead(busAddr));
      check("R7 irq flag", irqReq, mIrq);
    end
  end

  task automatic busWrite(input int a, input int d);
    @(negedge clk);
    busAddr = a[1:0]; busWdata = d[7:0]; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic idle(input int n, input int a);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busAddr = a[1:0];
    end
  endtask

  initial begin
    int lastRise, gap, rises;
    repeat (3) @(negedge clk);
    // R1: reset values visible at the ports before release
    busAddr = 0; #1 check("R1 reset prescaler", busRdata, 255);
    busAddr = 1; #1 check("R1 reset timer", busRdata, 255);
    busAddr = 2; #1 check("R1 reset halt", busRdata, 0);
    check("R1 reset irq", irqReq, 0);
    rstN = 1'b1;
    idle(40, 0);
    idle(40, 1);
    // R5, R6: short reloads, then period measurement for R3/R4
    busWrite(0, 1);
    busWrite(1, 2);
    idle(20, 1);
    lastRise = -1; rises = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      busAddr = (i % 2) ? 2'd0 : 2'd1;
      irqClear = 1'b0;
      if (irqReq) begin
        if (lastRise >= 0) begin
          gap = cycle - lastRise;
          check("R3 R4 underflow period", gap, 96);
        end
        lastRise = cycle;
        rises++;
        irqClear = 1'b1;
      end
    end
    irqClear = 1'b0;
    check("R7 irq repeated", rises >= 6, 1);
    // R9: write landing on a count-enable cycle
    for (int k = 0; k < 3; k++) begin
      while (mDiv != 14) @(negedge clk);
      busWrite(0, 0);
      idle(3, 0);
      while (mDiv != 14) @(negedge clk);
      busWrite(1, 0);
      idle(20, 1);
    end
    // R7: clear held high across underflows, set must win
    busWrite(0, 0);
    busWrite(1, 0);
    irqClear = 1'b1;
    idle(100, 1);
    irqClear = 1'b0;
    idle(5, 1);
    // R8: halt freezes both stages, divider phase retained
    busWrite(0, 5);
    busWrite(2, 1);
    idle(80, 0);
    idle(40, 2);
    busWrite(2, 0);
    idle(60, 0);
    // R10: address 3 ignored
    busWrite(3, 255);
    idle(4, 3);
    idle(4, 0);
    idle(4, 1);
    idle(4, 2);
    busWrite(0, 3);
    busWrite(1, 4);
    idle(400, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule